// File: doc/BRIEF.md
# Commutation Shadow Register Control

This block keeps, for each of up to four output channels, three control items: a main output enable, a complementary output enable and a compare mode field. For channels that drive a complementary pair, each item exists twice: a staged copy and a live copy. A configuration bit picks where software writes land. With staging off, a write reaches the live copy directly. With staging on, a write only fills the staged copy, and the live copy takes it over on a commutation event.

A second configuration bit selects the commutation source. One setting uses only a software request pulse. The other uses the software request or a rising edge of a trigger input. Channels built without a complementary output ignore staging: their writes always go straight to the live copy, and commutation events never touch them. The live copies feed the waveform generator that sits next to this block. Waveform generation and dead-time insertion are not part of this block.

A software commutation request is also reflected on a self-clearing status bit. That bit reads 1 in the cycle after the request and 0 after that.

Top module: `comm_shadow_ctrl`

## Requirements
- R1: After reset, every live enable bit, every live mode field (0 = frozen) and the request status bit read 0.
- R2: With staging off (`stage_en_i`=0), a write to any channel appears on that channel's live outputs after the next clock edge, and a commutation request moves nothing.
- R3: With staging on, a write to a complementary-capable channel leaves its live outputs unchanged until a commutation event occurs.
- R4: With staging on, a software request (`com_req_i`=1) copies every complementary-capable channel's staged items into its live outputs at the same clock edge.
- R5: With trigger updates off (`trig_upd_en_i`=0), a rising edge on `trig_i` causes no transfer.
- R6: With staging on and trigger updates on, a 0-to-1 change of `trig_i` between consecutive clock samples transfers once; holding `trig_i` high causes no further transfer.
- R7: A channel whose bit in `HAS_COMP` is 0 takes writes directly even with staging on, and no commutation event alters it.
- R8: The status bit `com_flag_o` reads 1 in the cycle after a request and returns to 0 in the following cycle when the request is not repeated.
- R9: When a write to a channel and a transfer fall in the same cycle, the live outputs take the value being written.
- R10: A single event transfers all complementary-capable channels together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_en_i | input | 1 | 1 = writes to complementary channels are staged |
| trig_upd_en_i | input | 1 | 1 = a trigger rising edge also commutes |
| wr_en_i | input | 1 | Write strobe for one channel |
| wr_ch_i | input | CH_W | Channel index of the write |
| wr_main_i | input | 1 | Main output enable value |
| wr_comp_i | input | 1 | Complementary output enable value |
| wr_mode_i | input | MODE_W | Compare mode value |
| com_req_i | input | 1 | Software commutation request pulse |
| trig_i | input | 1 | Trigger input level |
| act_main_o | output | NUM_CH | Live main enables, bit k = channel k |
| act_comp_o | output | NUM_CH | Live complementary enables |
| act_mode_o | output | NUM_CH*MODE_W | Live mode fields, channel k at bits k*MODE_W upward |
| com_flag_o | output | 1 | Self-clearing request status |

## Verification
The hardest case to reach is a trigger that stays high after its edge while new values sit in the staging registers. Only that case shows whether the edge detector really produces a single transfer. The stimulus raises the trigger with updates enabled, then writes a new staged value while keeping the trigger high, and checks that the live copy does not move. It then drops and raises the trigger again to see the transfer happen. A write that lands in the same cycle as a request is driven on purpose to check that the new value wins.

// File: rtl/comm_shadow_pkg.sv
package comm_shadow_pkg;
    parameter int unsigned MODE_W = 3;

    typedef struct packed {
        logic              main_en;
        logic              comp_en;
        logic [MODE_W-1:0] mode;
    } ch_ctrl_t;

    typedef struct packed {
        ch_ctrl_t act;
        ch_ctrl_t shd;
    } slot_state_t;
endpackage

// File: rtl/comm_trig_edge.sv
module comm_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = trig_i;
        rise_o = trig_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R6: a held level yields one pulse only
    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/comm_event_gen.sv
module comm_event_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic stage_en_i,
    input  logic trig_upd_en_i,
    input  logic com_req_i,
    input  logic trig_rise_i,
    output logic xfer_o,
    output logic com_flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = com_req_i;
        xfer_o = stage_en_i & (com_req_i | (trig_upd_en_i & trig_rise_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign com_flag_o = flag_q;

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        com_req_i |=> com_flag_o);
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !com_req_i |=> !com_flag_o);
    // R5: no trigger path when trigger updates are off
    p_no_trig_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_upd_en_i && !com_req_i) |-> !xfer_o);
endmodule

// File: rtl/comm_chan_slot.sv
module comm_chan_slot
    import comm_shadow_pkg::*;
#(
    parameter bit HAS_COMP = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stage_en_i,
    input  logic     wr_i,
    input  ch_ctrl_t wr_val_i,
    input  logic     xfer_i,
    output ch_ctrl_t act_o
);
    slot_state_t st_d, st_q;

    generate
        if (HAS_COMP) begin : g_comp
            always_comb begin
                st_d = st_q;
                if (wr_i) begin
                    st_d.shd = wr_val_i;
                    if (!stage_en_i) st_d.act = wr_val_i;
                end
                if (xfer_i) st_d.act = st_d.shd;
            end

            // R3: staged writes do not reach the live copy without an event
            p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_en_i && !xfer_i) |=> $stable(act_o));
            // R4: a transfer with no write publishes the staged value
            p_xfer_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_i && !wr_i) |=> act_o == $past(st_q.shd));
            // R9: a write in a transfer cycle wins
            p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_i && wr_i) |=> act_o == $past(wr_val_i));
        end else begin : g_plain
            logic unused_inputs;
            assign unused_inputs = stage_en_i ^ xfer_i;
            always_comb begin
                st_d     = st_q;
                st_d.shd = '0;
                if (wr_i) st_d.act = wr_val_i;
            end

            // R7: plain channels change only on a write
            p_plain_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_i |=> $stable(act_o));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    // R2: direct path when staging is off
    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !stage_en_i) |=> act_o == $past(wr_val_i));
endmodule

// File: rtl/comm_shadow_ctrl.sv
module comm_shadow_ctrl
    import comm_shadow_pkg::*;
#(
    parameter int unsigned      NUM_CH   = 4,
    parameter logic [NUM_CH-1:0] HAS_COMP = 4'b0111,
    localparam int unsigned     CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_en_i,
    input  logic                     trig_upd_en_i,
    input  logic                     wr_en_i,
    input  logic [CH_W-1:0]          wr_ch_i,
    input  logic                     wr_main_i,
    input  logic                     wr_comp_i,
    input  logic [MODE_W-1:0]        wr_mode_i,
    input  logic                     com_req_i,
    input  logic                     trig_i,
    output logic [NUM_CH-1:0]        act_main_o,
    output logic [NUM_CH-1:0]        act_comp_o,
    output logic [NUM_CH*MODE_W-1:0] act_mode_o,
    output logic                     com_flag_o
);
    logic     trig_rise;
    logic     xfer;
    ch_ctrl_t wr_val;

    assign wr_val = '{main_en: wr_main_i, comp_en: wr_comp_i, mode: wr_mode_i};

    comm_trig_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (trig_rise)
    );

    comm_event_gen u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .stage_en_i    (stage_en_i),
        .trig_upd_en_i (trig_upd_en_i),
        .com_req_i     (com_req_i),
        .trig_rise_i   (trig_rise),
        .xfer_o        (xfer),
        .com_flag_o    (com_flag_o)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic     wr_hit;
        ch_ctrl_t act;

        assign wr_hit = wr_en_i && (wr_ch_i == CH_W'(k));

        comm_chan_slot #(.HAS_COMP(HAS_COMP[k])) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .stage_en_i (stage_en_i),
            .wr_i       (wr_hit),
            .wr_val_i   (wr_val),
            .xfer_i     (xfer),
            .act_o      (act)
        );

        assign act_main_o[k]                  = act.main_en;
        assign act_comp_o[k]                  = act.comp_en;
        assign act_mode_o[k*MODE_W +: MODE_W] = act.mode;
    end

    // R1: cleared state right after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (act_main_o == '0 && act_comp_o == '0 && act_mode_o == '0 && !com_flag_o));
endmodule

// File: tb/comm_shadow_ctrl_test.sv
module comm_shadow_ctrl_test;
    localparam int NCH = 4;
    localparam int MW  = 3;
    localparam logic [NCH-1:0] HC = 4'b0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stage_en = 1'b0, trig_upd_en = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_ch = '0;
    logic wr_main = 1'b0, wr_comp = 1'b0;
    logic [MW-1:0] wr_mode = '0;
    logic com_req = 1'b0, trig = 1'b0;
    logic [NCH-1:0] act_main, act_comp;
    logic [NCH*MW-1:0] act_mode;
    logic com_flag;

    always #2 clk = ~clk;

    comm_shadow_ctrl #(.NUM_CH(NCH), .HAS_COMP(HC)) uut (
        .clk(clk), .rst_n(rst_n), .stage_en_i(stage_en), .trig_upd_en_i(trig_upd_en),
        .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_main_i(wr_main), .wr_comp_i(wr_comp),
        .wr_mode_i(wr_mode), .com_req_i(com_req), .trig_i(trig),
        .act_main_o(act_main), .act_comp_o(act_comp), .act_mode_o(act_mode),
        .com_flag_o(com_flag)
    );

    typedef struct {
        logic [NCH-1:0]    m;
        logic [NCH-1:0]    c;
        logic [NCH*MW-1:0] md;
        logic              f;
        string             tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // requirement model
    logic [NCH-1:0]    m_act_m = '0, m_act_c = '0, m_shd_m = '0, m_shd_c = '0;
    logic [NCH*MW-1:0] m_act_md = '0, m_shd_md = '0;
    logic              m_trig_prev = 1'b0;

    task automatic step(input logic rst, input logic w, input int ch, input logic mm,
                        input logic cc, input int md, input logic com, input logic tg,
                        input string tag);
        exp_t e;
        logic xf;
        @(negedge clk);
        rst_n = ~rst; wr_en = w; wr_ch = 2'(ch); wr_main = mm; wr_comp = cc;
        wr_mode = MW'(md); com_req = com; trig = tg;
        if (rst) begin
            m_act_m = '0; m_act_c = '0; m_shd_m = '0; m_shd_c = '0;
            m_act_md = '0; m_shd_md = '0; m_trig_prev = 1'b0;
            e.f = 1'b0;
        end else begin
            xf = stage_en && (com || (trig_upd_en && tg && !m_trig_prev));
            for (int k = 0; k < NCH; k++) begin
                if (w && ch == k) begin
                    if (HC[k]) begin
                        m_shd_m[k] = mm; m_shd_c[k] = cc; m_shd_md[k*MW +: MW] = MW'(md);
                    end
                    if (!HC[k] || !stage_en) begin
                        m_act_m[k] = mm; m_act_c[k] = cc; m_act_md[k*MW +: MW] = MW'(md);
                    end
                end
                if (xf && HC[k]) begin
                    m_act_m[k] = m_shd_m[k]; m_act_c[k] = m_shd_c[k];
                    m_act_md[k*MW +: MW] = m_shd_md[k*MW +: MW];
                end
            end
            m_trig_prev = tg;
            e.f = com;
        end
        e.m = m_act_m; e.c = m_act_c; e.md = m_act_md; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, trig, tag);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_run++;
                if (act_main !== e.m || act_comp !== e.c || act_mode !== e.md || com_flag !== e.f) begin
                    n_fail++;
                    $display("FAIL %s: main=%b comp=%b mode=%h flag=%b expected main=%b comp=%b mode=%h flag=%b",
                             e.tag, act_main, act_comp, act_mode, com_flag, e.m, e.c, e.md, e.f);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(1'b1, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1'b1, 0, 0, 0, 0, 0, 0, 0, "R1");
        idle("R1");
        // R2: direct writes
        step(1'b0, 1, 0, 1, 1, 6, 0, 0, "R2");
        step(1'b0, 1, 2, 0, 1, 3, 0, 0, "R2");
        step(1'b0, 0, 0, 0, 0, 0, 1, 0, "R2");
        idle("R8");
        // R3: staged
        stage_en = 1'b1;
        step(1'b0, 1, 0, 0, 0, 2, 0, 0, "R3");
        idle("R3");
        step(1'b0, 0, 0, 0, 0, 0, 1, 0, "R4");
        idle("R8");
        // R5: trigger path off
        step(1'b0, 1, 1, 1, 0, 5, 0, 0, "R5");
        step(1'b0, 0, 0, 0, 0, 0, 0, 1, "R5");
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R6: trigger path on
        trig_upd_en = 1'b1;
        step(1'b0, 0, 0, 0, 0, 0, 0, 1, "R6");
        step(1'b0, 1, 1, 1, 1, 7, 0, 1, "R6");
        step(1'b0, 0, 0, 0, 0, 0, 0, 1, "R6");
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1'b0, 0, 0, 0, 0, 0, 0, 1, "R6");
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R7: plain channel
        step(1'b0, 1, 3, 1, 1, 4, 0, 0, "R7");
        step(1'b0, 0, 0, 0, 0, 0, 1, 0, "R7");
        step(1'b0, 1, 3, 0, 1, 1, 0, 1, "R7");
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R9: write in transfer cycle
        step(1'b0, 1, 2, 1, 0, 5, 1, 0, "R9");
        idle("R9");
        // R10: all channels together
        step(1'b0, 1, 0, 1, 0, 1, 0, 0, "R10");
        step(1'b0, 1, 1, 0, 1, 6, 0, 0, "R10");
        step(1'b0, 1, 2, 1, 1, 2, 0, 0, "R10");
        step(1'b0, 0, 0, 0, 0, 0, 1, 0, "R10");
        idle("R8");
        idle("R8");
        @(posedge clk); #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule